// File: doc/BRIEF.md
# UART FIFO Control and Occupancy Unit

This block holds the transmit and receive byte queues of a 16550-style serial port, along with the control word that governs them. The serial shift logic pushes received bytes and pops bytes for transmission. Software reaches the block through two paths: single-cycle writes of a four-bit control word, and a receive occupancy count that it can read at any time.

Every receive entry stores its own parity, framing and break flags next to the data byte. A summary flag is raised while any stored entry carries an error. After reset the block runs in non-FIFO mode, where each direction holds a single byte. Setting the enable bit switches it to 64-deep queues. Any change of mode empties both queues.

The block drives the transmit data request and its interrupt. It also raises a one-cycle clear pulse toward the interrupt identification logic whenever the receive queue is flushed. Shift registers and the sticky line-status error bits are outside this block, and no command here touches them.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After synchronous reset the unit is in non-FIFO mode with transmit level 0. Both queues are empty, `rx_occupancy` is 0, `data_ready` and `fifo_error` are 0, and `tx_data_req` is 1.
- R2: `rx_occupancy` rises by one for each accepted receive push and falls by one for each accepted pop. When a push and a pop are accepted in the same cycle, the count is unchanged. The count can reach 64.
- R3: A push into a full queue is dropped. The count stays the same and the byte is not stored. `rx_full` and `tx_full` flag a full queue.
- R4: Both queues are first-in first-out. `rx_rdata` and `rx_rerr` show the oldest receive byte and its own error flags (bit 0 parity, bit 1 framing, bit 2 break).
- R5: In FIFO mode with transmit level 0, `tx_data_req` is 1 while 32 or fewer bytes are queued. With level 1 it is 1 only when the transmit queue is empty. `tx_int` equals `tx_data_req` AND `tx_int_en`.
- R6: Control bit 0 is enable, bit 1 is receive flush, bit 2 is transmit flush and bit 3 is transmit level. A write with bits 0 and 2 set empties the transmit queue and raises `tx_data_req`, and leaves the receive queue untouched.
- R7: A write with bits 0 and 1 set empties the receive queue, clearing `data_ready` and `fifo_error`, and leaves the transmit queue untouched. `rda_clear` is 1 for exactly the cycle after any receive flush.
- R8: A write with bit 0 clear selects non-FIFO mode and empties both queues. Its bits 1 to 3 are ignored, so `tx_level` keeps its value.
- R9: Changing from non-FIFO to FIFO mode empties both queues. A write with bit 0 set, made while already in FIFO mode with bits 1 and 2 clear, keeps both queues' contents and only loads the level from bit 3.
- R10: In non-FIFO mode each queue holds one byte, so `rx_occupancy` reads only 0 or 1.
- R11: `fifo_error` is 1 exactly while at least one stored receive entry has a nonzero error field. It is re-evaluated as entries are popped.
- R12: A flush takes priority over a push in the same cycle, so the queue ends empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word: enable, receive flush, transmit flush, transmit level |
| fifo_mode | output | 1 | 1 when the 64-deep queues are in use |
| tx_level | output | 1 | Programmed transmit request level |
| rx_occupancy | output | 7 | Number of bytes held in the receive queue |
| tx_push | input | 1 | Write a byte into the transmit queue |
| tx_wdata | input | 8 | Transmit byte to write |
| tx_full | output | 1 | Transmit queue is full |
| tx_pop | input | 1 | Shift logic takes the oldest transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_int_en | input | 1 | Transmit interrupt enable |
| tx_data_req | output | 1 | Transmit data request (interrupt or DMA) |
| tx_int | output | 1 | Transmit-requests-data interrupt |
| rx_push | input | 1 | Shift logic delivers a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_werr | input | 3 | Error flags of the received byte |
| rx_full | output | 1 | Receive queue is full |
| rx_pop | input | 1 | Software takes the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| rx_rerr | output | 3 | Error flags of the oldest received byte |
| data_ready | output | 1 | At least one received byte is held |
| fifo_error | output | 1 | Some held receive entry has an error |
| rda_clear | output | 1 | Pulse clearing a pending received-data interrupt |

## Verification
The hardest condition to reach is a full 64-entry receive queue in which error flags sit on a sparse, known set of entries. Only then does `fifo_error` have to stay high across many pops and drop on exactly the pop that removes the last flagged entry. The stimulus fills the queue with data and error patterns computed from the entry index, pushes once more into the full queue, and drains it. At each step the bench checks the head byte, its flags and the summary flag against a scan of the indices still held. Level changes that must not flush, flushes that coincide with a push, and mode-off writes that carry stray field bits are each set up with known contents in both queues first.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_err_t;

    localparam int ERR_W = $bits(rx_err_t);

    typedef struct packed {
        rx_err_t           err;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    localparam int RX_W = $bits(rx_entry_t);

    typedef struct packed {
        logic tx_lvl;
        logic tx_rst;
        logic rx_rst;
        logic en;
    } ctl_word_t;

    function automatic logic has_err(rx_err_t e);
        return |e;
    endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             one_deep,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    output logic             full,
    output logic             push_ok,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             pop_ok,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cap;

    function automatic logic [AW-1:0] adv(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap     = one_deep ? CW'(1) : CW'(DEPTH);
    assign full    = (count >= cap);
    assign push_ok = push && !full;
    assign pop_ok  = pop && (count != '0);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= adv(wp);
            if (pop_ok)  rp <= adv(rp);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_fifo_ctl_reg.sv
module uart_fifo_ctl_reg
    import uart_fifo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  ctl_word_t wdata,
    output logic      fifo_mode,
    output logic      tx_lvl,
    output logic      rx_flush,
    output logic      tx_flush,
    output logic      rda_clr
);
    always_comb begin
        rx_flush = 1'b0;
        tx_flush = 1'b0;
        if (wr) begin
            if (!wdata.en) begin
                rx_flush = 1'b1;
                tx_flush = 1'b1;
            end else begin
                rx_flush = wdata.rx_rst || !fifo_mode;
                tx_flush = wdata.tx_rst || !fifo_mode;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_mode <= 1'b0;
            tx_lvl    <= 1'b0;
            rda_clr   <= 1'b0;
        end else begin
            rda_clr <= rx_flush;
            if (wr) begin
                fifo_mode <= wdata.en;
                if (wdata.en) tx_lvl <= wdata.tx_lvl;
            end
        end
    end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [3:0]        ctl_wdata,
    output logic              fifo_mode,
    output logic              tx_level,
    output logic [CW-1:0]     rx_occupancy,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_wdata,
    output logic              tx_full,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_rdata,
    output logic              tx_empty,
    input  logic              tx_int_en,
    output logic              tx_data_req,
    output logic              tx_int,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_wdata,
    input  logic [ERR_W-1:0]  rx_werr,
    output logic              rx_full,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_rdata,
    output logic [ERR_W-1:0]  rx_rerr,
    output logic              data_ready,
    output logic              fifo_error,
    output logic              rda_clear
);
    logic          rx_flush, tx_flush;
    logic          rx_push_ok, rx_pop_ok, tx_push_ok, tx_pop_ok;
    logic [CW-1:0] tx_cnt, err_cnt;
    rx_entry_t     rx_in, rx_out;

    uart_fifo_ctl_reg u_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr        (ctl_wr),
        .wdata     (ctl_word_t'(ctl_wdata)),
        .fifo_mode (fifo_mode),
        .tx_lvl    (tx_level),
        .rx_flush  (rx_flush),
        .tx_flush  (tx_flush),
        .rda_clr   (rda_clear)
    );

    byte_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txq (
        .clk      (clk),
        .rst      (rst),
        .flush    (tx_flush),
        .one_deep (!fifo_mode),
        .push     (tx_push),
        .din      (tx_wdata),
        .full     (tx_full),
        .push_ok  (tx_push_ok),
        .pop      (tx_pop),
        .dout     (tx_rdata),
        .pop_ok   (tx_pop_ok),
        .count    (tx_cnt)
    );

    assign rx_in.err  = rx_err_t'(rx_werr);
    assign rx_in.data = rx_wdata;

    byte_fifo #(.WIDTH(RX_W), .DEPTH(DEPTH)) u_rxq (
        .clk      (clk),
        .rst      (rst),
        .flush    (rx_flush),
        .one_deep (!fifo_mode),
        .push     (rx_push),
        .din      (rx_in),
        .full     (rx_full),
        .push_ok  (rx_push_ok),
        .pop      (rx_pop),
        .dout     (rx_out),
        .pop_ok   (rx_pop_ok),
        .count    (rx_occupancy)
    );

    assign rx_rdata   = rx_out.data;
    assign rx_rerr    = rx_out.err;
    assign data_ready = (rx_occupancy != '0);

    // Count of held receive entries whose error field is nonzero.
    always_ff @(posedge clk) begin
        if (rst || rx_flush) begin
            err_cnt <= '0;
        end else begin
            case ({rx_push_ok && has_err(rx_in.err), rx_pop_ok && has_err(rx_out.err)})
                2'b10:   err_cnt <= err_cnt + 1'b1;
                2'b01:   err_cnt <= err_cnt - 1'b1;
                default: err_cnt <= err_cnt;
            endcase
        end
    end
    assign fifo_error = (err_cnt != '0);

    assign tx_empty    = (tx_cnt == '0);
    assign tx_data_req = (fifo_mode && !tx_level) ? (tx_cnt <= CW'(DEPTH / 2)) : tx_empty;
    assign tx_int      = tx_data_req && tx_int_en;
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          ctl_wr,
    input logic [3:0]    ctl_wdata,
    input logic          fifo_mode,
    input logic          tx_level,
    input logic [CW-1:0] rx_occupancy,
    input logic          rx_flush,
    input logic          tx_flush,
    input logic          rx_push,
    input logic          rx_pop,
    input logic          rx_full,
    input logic          rx_push_ok,
    input logic          rx_pop_ok,
    input logic          tx_empty,
    input logic          tx_data_req,
    input logic          data_ready,
    input logic          fifo_error,
    input logic          rda_clear
);
    assert_occ_bound_R10: assert property (@(posedge clk) disable iff (rst)
        rx_occupancy <= (fifo_mode ? CW'(DEPTH) : CW'(1)));

    assert_occ_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (!rx_flush && rx_push_ok && !rx_pop_ok) |=> rx_occupancy == CW'($past(rx_occupancy) + 1'b1));

    assert_occ_dec_R2: assert property (@(posedge clk) disable iff (rst)
        (!rx_flush && rx_pop_ok && !rx_push_ok) |=> rx_occupancy == CW'($past(rx_occupancy) - 1'b1));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_full && rx_push && !rx_pop && !rx_flush) |=> $stable(rx_occupancy));

    assert_tx_flush_R6: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> (tx_empty && tx_data_req));

    assert_rx_flush_R7: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> (rx_occupancy == '0 && !data_ready && !fifo_error && rda_clear));

    assert_rda_empty_R7: assert property (@(posedge clk) disable iff (rst)
        rda_clear |-> !data_ready);

    assert_mode_off_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_wdata[0]) |=> (!fifo_mode && tx_empty && rx_occupancy == '0 && $stable(tx_level)));

    assert_level_one_R5: assert property (@(posedge clk) disable iff (rst)
        (fifo_mode && tx_level && tx_data_req) |-> tx_empty);

    assert_err_held_R11: assert property (@(posedge clk) disable iff (rst)
        fifo_error |-> data_ready);
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctl_wr       (ctl_wr),
    .ctl_wdata    (ctl_wdata),
    .fifo_mode    (fifo_mode),
    .tx_level     (tx_level),
    .rx_occupancy (rx_occupancy),
    .rx_flush     (rx_flush),
    .tx_flush     (tx_flush),
    .rx_push      (rx_push),
    .rx_pop       (rx_pop),
    .rx_full      (rx_full),
    .rx_push_ok   (rx_push_ok),
    .rx_pop_ok    (rx_pop_ok),
    .tx_empty     (tx_empty),
    .tx_data_req  (tx_data_req),
    .data_ready   (data_ready),
    .fifo_error   (fifo_error),
    .rda_clear    (rda_clear)
);

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [3:0] ctl_wdata = '0;
    logic       fifo_mode, tx_level;
    logic [6:0] rx_occupancy;
    logic       tx_push = 1'b0, tx_pop = 1'b0, tx_int_en = 1'b0;
    logic [7:0] tx_wdata = '0, tx_rdata;
    logic       tx_full, tx_empty, tx_data_req, tx_int;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_wdata = '0, rx_rdata;
    logic [2:0] rx_werr = '0, rx_rerr;
    logic       rx_full, data_ready, fifo_error, rda_clear;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_fifo_ctl #(.DEPTH(DEPTH)) i_uart_fifo_ctl (.*);

    task automatic check(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ctl_wr = 1'b0;
        tx_push = 1'b0;
        tx_pop = 1'b0;
        rx_push = 1'b0;
        rx_pop = 1'b0;
    endtask

    task automatic ctl(input logic [3:0] w);
        ctl_wr = 1'b1;
        ctl_wdata = w;
        tick();
    endtask

    task automatic rxp(input int d, input int e);
        rx_push = 1'b1;
        rx_wdata = d[7:0];
        rx_werr = e[2:0];
        tick();
    endtask

    task automatic txp(input int d);
        tx_push = 1'b1;
        tx_wdata = d[7:0];
        tick();
    endtask

    function automatic int fdat(int i);
        return (i * 37 + 5) % 256;
    endfunction

    function automatic int ferr(int i);
        return (i % 9 == 4) ? ((i / 9) % 7 + 1) : 0;
    endfunction

    function automatic int any_err(int lo, int hi);
        for (int j = lo; j <= hi; j++) if (ferr(j) != 0) return 1;
        return 0;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 mode", fifo_mode, 0);
        check("R1 level", tx_level, 0);
        check("R1 occ", rx_occupancy, 0);
        check("R1 ready", data_ready, 0);
        check("R1 ferr", fifo_error, 0);
        check("R1 txreq", tx_data_req, 1);
        check("R1 txempty", tx_empty, 1);

        // R10 non-FIFO: single holding byte each way
        rxp(8'h5A, 0);
        check("R10 occ1", rx_occupancy, 1);
        check("R10 full", rx_full, 1);
        rxp(8'h11, 0);
        check("R10 occ stays 1", rx_occupancy, 1);
        check("R10 head", rx_rdata, 8'h5A);
        txp(8'h33);
        check("R10 txreq", tx_data_req, 0);
        check("R10 txfull", tx_full, 1);
        rx_pop = 1'b1;
        tx_pop = 1'b1;
        tick();
        check("R10 occ0", rx_occupancy, 0);
        check("R10 txempty", tx_empty, 1);

        // R9 mode change 0->1 flushes
        rxp(8'h77, 1);
        txp(8'h44);
        ctl(4'b0001);
        check("R9 mode", fifo_mode, 1);
        check("R9 rx flushed", rx_occupancy, 0);
        check("R9 tx flushed", tx_empty, 1);
        check("R7 rda pulse on mode flush", rda_clear, 1);
        tick();
        check("R7 rda one cycle", rda_clear, 0);

        // R2 R3 R4 R11 full sweep
        for (int i = 0; i < DEPTH; i++) begin
            rxp(fdat(i), ferr(i));
            check("R2 occ up", rx_occupancy, i + 1);
            check("R11 ferr fill", fifo_error, any_err(0, i));
        end
        check("R3 rxfull", rx_full, 1);
        rxp(8'hEE, 7);
        check("R3 occ held", rx_occupancy, DEPTH);
        for (int k = 0; k < DEPTH; k++) begin
            check("R4 data", rx_rdata, fdat(k));
            check("R4 err", rx_rerr, ferr(k));
            check("R11 ferr drain", fifo_error, any_err(k, DEPTH - 1));
            rx_pop = 1'b1;
            tick();
            check("R2 occ down", rx_occupancy, DEPTH - 1 - k);
        end
        check("R3 dropped byte absent", data_ready, 0);
        check("R11 ferr empty", fifo_error, 0);

        // R2 simultaneous push and pop
        rxp(8'h10, 0);
        rx_push = 1'b1;
        rx_wdata = 8'h20;
        rx_werr = 3'd2;
        rx_pop = 1'b1;
        tick();
        check("R2 same count", rx_occupancy, 1);
        check("R4 new head", rx_rdata, 8'h20);
        check("R11 ferr new", fifo_error, 1);
        rx_pop = 1'b1;
        tick();

        // R5 level 0 sweep
        for (int n = 0; n <= DEPTH; n++) begin
            tx_int_en = n[0];
            #1;
            check("R5 lvl0 req", tx_data_req, (n <= DEPTH / 2) ? 1 : 0);
            check("R5 int", tx_int, ((n <= DEPTH / 2) && n[0]) ? 1 : 0);
            if (n < DEPTH) txp(n + 100);
        end
        check("R3 txfull", tx_full, 1);
        // R9 level change without flush
        ctl(4'b1001);
        check("R9 level set", tx_level, 1);
        check("R9 tx kept", tx_full, 1);
        for (int n = DEPTH; n > 0; n--) begin
            check("R5 lvl1 req", tx_data_req, 0);
            check("R4 tx order", tx_rdata, (DEPTH - n + 100) % 256);
            tx_pop = 1'b1;
            tick();
        end
        check("R5 lvl1 empty req", tx_data_req, 1);

        // R6 transmit flush
        for (int n = 0; n < 5; n++) txp(n);
        for (int n = 0; n < 3; n++) rxp(n, 0);
        ctl(4'b0101);
        check("R6 txempty", tx_empty, 1);
        check("R6 txreq", tx_data_req, 1);
        check("R6 rx kept", rx_occupancy, 3);
        check("R6 level loaded", tx_level, 0);

        // R7 receive flush
        rxp(8'h99, 4);
        check("R11 ferr set", fifo_error, 1);
        txp(1);
        txp(2);
        ctl(4'b0011);
        check("R7 occ", rx_occupancy, 0);
        check("R7 ready", data_ready, 0);
        check("R7 ferr", fifo_error, 0);
        check("R7 rda", rda_clear, 1);
        check("R7 tx kept", tx_empty, 0);
        tick();
        check("R7 rda drop", rda_clear, 0);

        // R12 flush beats concurrent push
        rxp(8'h01, 0);
        rx_push = 1'b1;
        rx_wdata = 8'h02;
        ctl_wr = 1'b1;
        ctl_wdata = 4'b0011;
        tick();
        check("R12 occ", rx_occupancy, 0);

        // R8 mode off ignores other fields
        rxp(8'h05, 1);
        ctl(4'b1110);
        check("R8 mode", fifo_mode, 0);
        check("R8 level kept", tx_level, 0);
        check("R8 rx empty", rx_occupancy, 0);
        check("R8 tx empty", tx_empty, 1);
        check("R8 ferr", fifo_error, 0);
        check("R8 rda", rda_clear, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule